// File: doc/BRIEF.md
# I2C Bus Start/Stop Monitor

This block watches the SDA and SCL lines of an I2C bus. Both lines must already be synchronized to the local clock. It recognises the two framing events of the bus. A start is SDA going low while SCL stays high. A stop is SDA going high while SCL stays high. From these events the block keeps a start-seen bit and a stop-seen bit, and the two bits exclude each other.

A multi-master controller reads the derived bus-free signal before it tries to take the bus. The bus counts as free when the last event seen was a stop, or when no event has been seen since the monitor was enabled.

The block can also raise an interrupt when a stop is detected, so that software learns when a busy bus becomes free. Detection keeps running whatever the rest of the controller does, including after a lost arbitration. The block never drives the bus and does not decode addresses.

Top module: `i2cBusMonitor`

## Requirements
- R1: While rstN is low, startSeen, stopSeen and irqFlag are all 0.
- R2: A start is sampled when SCL is high in both the previous and the current sample, and SDA is 1 in the previous sample and 0 in the current one. On the clock edge that takes the current sample, startSeen becomes 1 and stopSeen becomes 0.
- R3: A stop is sampled when SCL is high in both samples, and SDA is 0 in the previous sample and 1 in the current one. On that edge stopSeen becomes 1 and startSeen becomes 0.
- R4: An SDA change is ignored when SCL is low in either of the two samples. This includes the cycle in which SCL rises. After such a change, startSeen and stopSeen keep their values.
- R5: busFree is 1 exactly when stopSeen is 1 or both status bits are 0. startSeen and stopSeen are never 1 together.
- R6: A detected stop sets irqFlag on the same edge when irqEnable is 1. When irqEnable is 0, a stop leaves irqFlag unchanged.
- R7: irqFlag stays set until irqClear is 1 for one cycle. If a stop with irqEnable and irqClear fall in the same cycle, the flag stays set.
- R8: While enable is 0, startSeen and stopSeen are 0 one cycle later and stay 0. No start or stop is detected while enable is 0.
- R9: A repeated start, arriving while startSeen is already 1, keeps startSeen at 1 and busFree at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Monitor enable; 0 clears and holds the status bits |
| sdaIn | input | 1 | Synchronized SDA level |
| sclIn | input | 1 | Synchronized SCL level |
| irqEnable | input | 1 | Allows a detected stop to set irqFlag |
| irqClear | input | 1 | One-cycle clear of irqFlag |
| startSeen | output | 1 | A start was the last event seen |
| stopSeen | output | 1 | A stop was the last event seen |
| busFree | output | 1 | The bus may be taken |
| irqFlag | output | 1 | Sticky stop interrupt flag |

## Verification
A detected stop with irqEnable high can arrive in the same cycle as irqClear, and the set must then win. A directed case builds a stop, holds irqClear high on the sampling cycle, and expects irqFlag to be 1 afterwards. The case is then repeated with irqEnable low, where the clear must win. The random phase drives SDA, SCL, enable, irqEnable and irqClear independently, so these collisions and SCL-rise-with-SDA-change cases also occur by chance. A cycle model in the bench judges each result.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  // strobes from the condition detector to the status datapath
  typedef struct packed {
    logic start;
    logic stop;
  } condStrobe_t;

  localparam logic IDLE_SDA = 1'b1;
  localparam logic RESET_SCL = 1'b0;
endpackage

// File: rtl/i2cCondDetect.sv
module i2cCondDetect
  import i2c_mon_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        sdaIn,
  input  logic        sclIn,
  output condStrobe_t strb
);
  logic sdaQ, sclQ, sclStable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaQ <= IDLE_SDA;
      sclQ <= RESET_SCL;
    end else begin
      sdaQ <= sdaIn;
      sclQ <= sclIn;
    end
  end

  always_comb begin
    sclStable  = sclQ & sclIn;
    strb.start = enable & sclStable & sdaQ & ~sdaIn;
    strb.stop  = enable & sclStable & ~sdaQ & sdaIn;
  end

  // R4: a start strobe only with SCL high on both samples
  p_start_scl_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |-> (sclIn && $past(sclIn)));
  // R4: a stop strobe only with SCL high on both samples
  p_stop_scl_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.stop |-> (sclIn && $past(sclIn)));
endmodule

// File: rtl/i2cBusStatus.sv
module i2cBusStatus
  import i2c_mon_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  condStrobe_t strb,
  input  logic        irqEnable,
  input  logic        irqClear,
  output logic        startSeen,
  output logic        stopSeen,
  output logic        busFree,
  output logic        irqFlag
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startSeen <= 1'b0;
      stopSeen  <= 1'b0;
    end else if (!enable) begin
      startSeen <= 1'b0;
      stopSeen  <= 1'b0;
    end else if (strb.start) begin
      startSeen <= 1'b1;
      stopSeen  <= 1'b0;
    end else if (strb.stop) begin
      startSeen <= 1'b0;
      stopSeen  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       irqFlag <= 1'b0;
    else if (strb.stop && irqEnable) irqFlag <= 1'b1;
    else if (irqClear)               irqFlag <= 1'b0;
  end

  assign busFree = stopSeen | (~startSeen & ~stopSeen);

  p_start_sets_s_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && strb.start) |=> (startSeen && !stopSeen));
  p_stop_sets_p_r3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && strb.stop) |=> (stopSeen && !startSeen));
  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(startSeen && stopSeen));
  p_off_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!startSeen && !stopSeen));
  p_irq_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stop && irqEnable) |=> irqFlag);
  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqClear && !(strb.stop && irqEnable)) |=> !irqFlag);
endmodule

// File: rtl/i2cBusMonitor.sv
module i2cBusMonitor
  import i2c_mon_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic sdaIn,
  input  logic sclIn,
  input  logic irqEnable,
  input  logic irqClear,
  output logic startSeen,
  output logic stopSeen,
  output logic busFree,
  output logic irqFlag
);
  condStrobe_t strb;

  i2cCondDetect detect (
    .clk(clk), .rstN(rstN), .enable(enable),
    .sdaIn(sdaIn), .sclIn(sclIn), .strb(strb)
  );

  i2cBusStatus status (
    .clk(clk), .rstN(rstN), .enable(enable), .strb(strb),
    .irqEnable(irqEnable), .irqClear(irqClear),
    .startSeen(startSeen), .stopSeen(stopSeen),
    .busFree(busFree), .irqFlag(irqFlag)
  );
endmodule

// File: tb/i2cBusMonitor_test.sv
`timescale 1ns/1ps
module i2cBusMonitor_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, sdaIn = 1'b1, sclIn = 1'b1, irqEnable = 1'b0, irqClear = 1'b0;
  logic startSeen, stopSeen, busFree, irqFlag;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic mS, mP, mIrq, mSda, mScl;

  always #10 clk = ~clk;

  i2cBusMonitor uut (
    .clk(clk), .rstN(rstN), .enable(enable), .sdaIn(sdaIn), .sclIn(sclIn),
    .irqEnable(irqEnable), .irqClear(irqClear),
    .startSeen(startSeen), .stopSeen(stopSeen), .busFree(busFree), .irqFlag(irqFlag)
  );

  function automatic logic expFree(input logic s, input logic p);
    return p | (~s & ~p);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    chk("R2 startSeen", startSeen, mS);
    chk("R3 stopSeen", stopSeen, mP);
    chk("R5 busFree", busFree, expFree(mS, mP));
    chk("R6 irqFlag", irqFlag, mIrq);
  endtask

  // one cycle: drive on negedge, update the model at posedge, sample 5 ns later
  task automatic step(input logic sda, input logic scl, input logic en,
                      input logic ie, input logic clr);
    logic st, sp;
    @(negedge clk);
    sdaIn = sda; sclIn = scl; enable = en; irqEnable = ie; irqClear = clr;
    @(posedge clk);
    st = en & mScl & scl & mSda & ~sda;
    sp = en & mScl & scl & ~mSda & sda;
    if (!en) begin mS = 0; mP = 0; end
    else if (st) begin mS = 1; mP = 0; end
    else if (sp) begin mS = 0; mP = 1; end
    if (sp && ie) mIrq = 1;
    else if (clr) mIrq = 0;
    mSda = sda; mScl = scl;
    #5;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mS = 0; mP = 0; mIrq = 0; mSda = 1; mScl = 0;
    repeat (3) @(posedge clk);
    #5;
    chk("R1 reset startSeen", startSeen, 1'b0);
    chk("R1 reset stopSeen", stopSeen, 1'b0);
    chk("R1 reset irqFlag", irqFlag, 1'b0);
    chk("R5 busFree idle", busFree, 1'b1);
    @(negedge clk); rstN = 1'b1;

    // R2: start
    step(1,1,1,0,0); step(0,1,1,0,0);
    chk("R2 start sets S", startSeen, 1'b1);
    chk("R5 busFree low when busy", busFree, 1'b0);
    // R4: data changes with SCL low; SDA change on the SCL rise
    step(0,0,1,0,0); step(1,0,1,0,0); step(0,0,1,0,0); step(1,1,1,0,0);
    chk("R4 SDA change on SCL rise ignored", stopSeen, 1'b0);
    chk("R4 S kept", startSeen, 1'b1);
    step(1,0,1,0,0); step(0,0,1,0,0);
    // R9: repeated start
    step(1,0,1,0,0); step(1,1,1,0,0); step(0,1,1,0,0);
    chk("R9 repeated start keeps S", startSeen, 1'b1);
    checkAll();
    // R6: stop with irq disabled
    step(0,0,1,0,0); step(0,1,1,0,0); step(1,1,1,0,0);
    chk("R3 stop sets P", stopSeen, 1'b1);
    chk("R6 no irq when disabled", irqFlag, 1'b0);
    // R6: start then stop with irq enabled
    step(0,1,1,1,0); step(0,0,1,1,0); step(0,1,1,1,0); step(1,1,1,1,0);
    chk("R6 stop sets irq", irqFlag, 1'b1);
    step(1,1,1,1,0);
    chk("R7 irq sticky", irqFlag, 1'b1);
    step(1,1,1,1,1);
    chk("R7 irq cleared", irqFlag, 1'b0);
    // R7: stop and clear in the same cycle, set wins
    step(0,1,1,1,0); step(0,0,1,1,0); step(0,1,1,1,0); step(1,1,1,1,1);
    chk("R7 set wins over clear", irqFlag, 1'b1);
    // R7: same collision with irqEnable low, clear wins
    step(0,1,1,0,0); step(0,0,1,0,0); step(0,1,1,0,0); step(1,1,1,0,1);
    chk("R7 clear wins without enable", irqFlag, 1'b0);
    // R8: disable clears and blocks detection
    step(1,1,0,0,0);
    chk("R8 disable clears P", stopSeen, 1'b0);
    step(0,1,0,0,0);
    chk("R8 start ignored when off", startSeen, 1'b0);
    step(1,1,0,1,0);
    chk("R8 stop ignored when off", stopSeen, 1'b0);
    chk("R8 no irq when off", irqFlag, 1'b0);
    checkAll();

    // random phase, biased toward SCL high so conditions occur
    for (int i = 0; i < 2000; i++) begin
      logic rs, rc, re, ri, rk;
      rs = 1'($urandom % 2);
      rc = (($urandom % 4) != 0);
      re = (($urandom % 16) != 0);
      ri = 1'($urandom % 2);
      rk = (($urandom % 8) == 0);
      step(rs, rc, re, ri, rk);
      checkAll();
    end

    // R1: reset in the middle of activity
    @(negedge clk); rstN = 1'b0;
    #5;
    chk("R1 async reset S", startSeen, 1'b0);
    chk("R1 async reset P", stopSeen, 1'b0);
    chk("R1 async reset irq", irqFlag, 1'b0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule